// File: doc/BRIEF.md
# Maskable Interrupt Controller with Global Enable

This block gathers four interrupt causes for a small 8-bit microcontroller core and turns them into one request line. The causes are a timer overflow pulse, an external pin whose active edge can be chosen, a change on a 4-bit group of port inputs, and a nonvolatile-memory write-done pulse. Each cause latches a flag. Each flag has its own enable bit, and a master enable gates all of them.

The core sees `irq` whenever the master enable is set and at least one flag is pending with its enable set. When the core takes the interrupt it pulses `irq_ack`, which clears the master enable so that the handler runs without being interrupted again. The handler ends with a `ret_strobe` pulse, which sets the master enable again. Software reads and writes the control register and an auxiliary flag register over a simple synchronous register bus.

The control register answers at two addresses, so it is visible from either register bank. The external pin and the port inputs pass through a synchroniser before any edge or change is detected.

Top module: `intr_hub`

## Requirements
- R1: After reset the control register reads 0x00, the auxiliary register reads 0x00 and `irq` is 0.
- R2: The control register is read and written at address 0x0B and at address 0x8B with the same contents. Its bit layout is: 7 master enable, 6 memory-done enable, 5 timer enable, 4 pin enable, 3 port enable, 2 timer flag, 1 pin flag, 0 port flag. The auxiliary register at 0x88 holds the memory-done flag in bit 0 and reads 0 in bits 7:1. Any other address reads 0x00.
- R3: `irq` is 1 exactly when the master enable is 1 and some source has both its flag and its enable at 1. It follows the register state in the same cycle.
- R4: On a clock edge with `irq_ack` high the master enable clears, so `irq` drops.
- R5: On a clock edge with `ret_strobe` high the master enable sets. When `irq_ack` is high on the same edge, the clear wins.
- R6: A flag latches whether or not its enable bit is set. A flag is cleared only by a register write of 0 to its bit. A register write of 1 sets the flag.
- R7: When a hardware event and a register write that clears the same flag land on the same edge, the flag ends up set.
- R8: With `ext_rise`=1 a low-to-high change of `ext_pin` sets the pin flag. With `ext_rise`=0 a high-to-low change sets it. The opposite edge has no effect. The flag sets on the third rising clock edge after the pin change, and not before.
- R9: A change in any bit of `port_hi` sets the port flag on the third rising clock edge after the change. A steady `port_hi` sets nothing.
- R10: A `tmr_ovf` pulse sets control bit 2 on the next edge. A `nvm_done` pulse sets auxiliary bit 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| nvm_done | input | 1 | Memory write-complete pulse |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_rise | input | 1 | Pin edge select: 1 rising, 0 falling |
| port_hi | input | 4 | Monitored port inputs (asynchronous) |
| irq | output | 1 | Interrupt request to the core |
| irq_ack | input | 1 | Core takes the interrupt |
| ret_strobe | input | 1 | Return from interrupt |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a 4-bit port group, and the control register mirrored at 0x0B and 0x8B with the auxiliary register at 0x88. With these defaults the exact three-edge detection latency can be pinned down, both mirror addresses and an unmapped address can be probed, and collisions between writes, hardware events, acknowledge and return can all be driven in the same cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int DATA_W      = 8;
  localparam int BIT_GIE     = 7;
  localparam int BIT_EN_NVM  = 6;
  localparam int BIT_EN_TMR  = 5;
  localparam int BIT_EN_EXT  = 4;
  localparam int BIT_EN_PORT = 3;
  localparam int BIT_F_TMR   = 2;
  localparam int BIT_F_EXT   = 1;
  localparam int BIT_F_PORT  = 0;

  typedef struct packed {
    logic nvm;
    logic tmr;
    logic ext;
    logic port;
  } src_t;

  // request: master enable and any flag/enable pair
  function automatic logic pending(input logic [DATA_W-1:0] ctrl, input logic nvm_flag);
    logic hit;
    hit = (ctrl[BIT_EN_NVM]  & nvm_flag)
        | (ctrl[BIT_EN_TMR]  & ctrl[BIT_F_TMR])
        | (ctrl[BIT_EN_EXT]  & ctrl[BIT_F_EXT])
        | (ctrl[BIT_EN_PORT] & ctrl[BIT_F_PORT]);
    return ctrl[BIT_GIE] & hit;
  endfunction

  // selected edge between previous and current sample
  function automatic logic edge_hit(input logic prev, input logic now, input logic rise);
    return (prev != now) && (now == rise);
  endfunction
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/intr_detect.sv
module intr_detect
  import intr_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_s,
  input  logic              ext_rise,
  input  logic [PORT_W-1:0] port_s,
  output logic              ext_evt,
  output logic              port_evt
);
  logic              ext_prev_q;
  logic [PORT_W-1:0] port_prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_prev_q  <= 1'b0;
      port_prev_q <= '0;
    end else begin
      ext_prev_q  <= ext_s;
      port_prev_q <= port_s;
    end

  assign ext_evt  = edge_hit(ext_prev_q, ext_s, ext_rise);
  assign port_evt = |(port_prev_q ^ port_s);
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR_B = 8'h8B,
  parameter logic [ADDR_W-1:0] AUX_ADDR    = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  src_t              evt,
  input  logic              irq_ack,
  input  logic              ret_strobe,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              nvm_q
);
  logic              sel_ctrl, sel_aux;
  logic [DATA_W-1:0] ctrl_d;
  logic              nvm_d;

  assign sel_ctrl = (bus_addr == CTRL_ADDR_A) || (bus_addr == CTRL_ADDR_B);
  assign sel_aux  = (bus_addr == AUX_ADDR);

  always_comb begin
    ctrl_d = ctrl_q;
    nvm_d  = nvm_q;
    if (bus_wr && sel_ctrl) ctrl_d = bus_wdata;
    if (bus_wr && sel_aux)  nvm_d  = bus_wdata[0];
    // hardware sets override software writes
    if (evt.tmr)  ctrl_d[BIT_F_TMR]  = 1'b1;
    if (evt.ext)  ctrl_d[BIT_F_EXT]  = 1'b1;
    if (evt.port) ctrl_d[BIT_F_PORT] = 1'b1;
    if (evt.nvm)  nvm_d              = 1'b1;
    // master enable: acknowledge beats return
    if (ret_strobe) ctrl_d[BIT_GIE] = 1'b1;
    if (irq_ack)    ctrl_d[BIT_GIE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      nvm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      nvm_q  <= nvm_d;
    end

  always_comb begin
    if (sel_ctrl)     bus_rdata = ctrl_q;
    else if (sel_aux) bus_rdata = {{(DATA_W-1){1'b0}}, nvm_q};
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_pkg::*;
#(
  parameter int               ADDR_W      = 8,
  parameter int               PORT_W      = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR_B = 8'h8B,
  parameter logic [ADDR_W-1:0] AUX_ADDR    = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tmr_ovf,
  input  logic              nvm_done,
  input  logic              ext_pin,
  input  logic              ext_rise,
  input  logic [PORT_W-1:0] port_hi,
  output logic              irq,
  input  logic              irq_ack,
  input  logic              ret_strobe
);
  localparam int SYNC_W = PORT_W + 1;

  logic [SYNC_W-1:0] raw_in, synced;
  logic              ext_s;
  logic [PORT_W-1:0] port_s;
  logic              ext_evt, port_evt;
  src_t              evt;
  logic [DATA_W-1:0] ctrl_q;
  logic              nvm_q;
  // named state for the checker
  logic              gie, tmr_flag, nvm_flag;

  assign raw_in = {ext_pin, port_hi};
  assign ext_s  = synced[SYNC_W-1];
  assign port_s = synced[PORT_W-1:0];

  intr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  intr_detect #(.PORT_W(PORT_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .ext_s(ext_s), .ext_rise(ext_rise),
    .port_s(port_s), .ext_evt(ext_evt), .port_evt(port_evt)
  );

  assign evt.nvm  = nvm_done;
  assign evt.tmr  = tmr_ovf;
  assign evt.ext  = ext_evt;
  assign evt.port = port_evt;

  intr_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR_A(CTRL_ADDR_A),
    .CTRL_ADDR_B(CTRL_ADDR_B), .AUX_ADDR(AUX_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt),
    .irq_ack(irq_ack), .ret_strobe(ret_strobe),
    .ctrl_q(ctrl_q), .nvm_q(nvm_q)
  );

  assign gie      = ctrl_q[BIT_GIE];
  assign tmr_flag = ctrl_q[BIT_F_TMR];
  assign nvm_flag = nvm_q;
  assign irq      = pending(ctrl_q, nvm_q);
endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk #(
  parameter int               ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR_B = 8'h8B
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              tmr_ovf,
  input logic              nvm_done,
  input logic              irq,
  input logic              irq_ack,
  input logic              ret_strobe,
  input logic              gie,
  input logic              tmr_flag,
  input logic              nvm_flag
);
  // R4
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie);

  // R5
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !irq_ack) |=> gie);

  // R3
  masked_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

  // R10
  tmr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_flag);

  // R10
  nvm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_done |=> nvm_flag);

  // R6
  tmr_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_flag) |-> $past(bus_wr && !bus_wdata[2] &&
      (bus_addr == CTRL_ADDR_A || bus_addr == CTRL_ADDR_B)));
endmodule

bind intr_hub intr_hub_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR_A(CTRL_ADDR_A), .CTRL_ADDR_B(CTRL_ADDR_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .tmr_ovf(tmr_ovf), .nvm_done(nvm_done),
  .irq(irq), .irq_ack(irq_ack), .ret_strobe(ret_strobe),
  .gie(gie), .tmr_flag(tmr_flag), .nvm_flag(nvm_flag)
);

// File: tb/intr_hub_bench.sv
module intr_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LO = 8'h0B, A_HI = 8'h8B, A_AUX = 8'h88, A_NONE = 8'h42;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic       bus_wr = 0, tmr_ovf = 0, nvm_done = 0, ext_pin = 0, ext_rise = 1;
  logic [3:0] port_hi = 4'h0;
  logic       irq, irq_ack = 0, ret_strobe = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_ctrl;
  logic       m_nvm, m_e1, m_e2, m_ep;
  logic [3:0] m_p1, m_p2, m_pp;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_hub u_intr_hub (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .nvm_done(nvm_done), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .port_hi(port_hi), .irq(irq), .irq_ack(irq_ack), .ret_strobe(ret_strobe)
  );

  function automatic logic exp_irq(input logic [7:0] c, input logic n);
    logic [3:0] fl;
    fl = {n, c[2], c[1], c[0]};
    return c[7] && ((fl & c[6:3]) != 4'h0);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] c, input logic n);
    if (a == A_LO || a == A_HI) return c;
    if (a == A_AUX) return {7'h00, n};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    logic ev_e, ev_p;
    logic [7:0] c;
    logic n;
    if (!rst_n) begin
      m_ctrl = 0; m_nvm = 0; m_e1 = 0; m_e2 = 0; m_ep = 0;
      m_p1 = 0; m_p2 = 0; m_pp = 0;
    end else begin
      ev_e = (m_e2 != m_ep) && (ext_rise ? m_e2 : !m_e2);
      ev_p = (m_p2 != m_pp);
      m_ep = m_e2; m_e2 = m_e1; m_e1 = ext_pin;
      m_pp = m_p2; m_p2 = m_p1; m_p1 = port_hi;
      c = m_ctrl; n = m_nvm;
      if (bus_wr && (bus_addr == A_LO || bus_addr == A_HI)) c = bus_wdata;
      if (bus_wr && bus_addr == A_AUX) n = bus_wdata[0];
      if (tmr_ovf) c[2] = 1;
      if (ev_e) c[1] = 1;
      if (ev_p) c[0] = 1;
      if (nvm_done) n = 1;
      if (ret_strobe) c[7] = 1;
      if (irq_ack) c[7] = 0;
      m_ctrl = c; m_nvm = n;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int k = 1);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_wr = 0;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick();
    bus_wr = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5A17));
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    rd(A_LO, d);  chk("R1 ctrl", d, 8'h00);
    rd(A_AUX, d); chk("R1 aux", d, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    // R2 mirrors and unmapped address
    wr(A_LO, 8'h78);
    rd(A_HI, d);   chk("R2 mirror hi", d, 8'h78);
    wr(A_HI, 8'h79);
    rd(A_LO, d);   chk("R2 mirror lo / R6 sw set", d, 8'h79);
    rd(A_NONE, d); chk("R2 unmapped", d, 8'h00);
    chk("R3 gie off", {7'h0, irq}, 8'h00);
    // R3 request
    wr(A_LO, 8'hF9);
    chk("R3 irq on", {7'h0, irq}, 8'h01);
    // R4 acknowledge
    irq_ack = 1; tick(); irq_ack = 0;
    rd(A_LO, d); chk("R4 gie cleared", d, 8'h79);
    chk("R4 irq dropped", {7'h0, irq}, 8'h00);
    // R5 return, then collision with ack
    ret_strobe = 1; tick(); ret_strobe = 0;
    rd(A_LO, d); chk("R5 gie set", d, 8'hF9);
    ret_strobe = 1; irq_ack = 1; tick(); ret_strobe = 0; irq_ack = 0;
    rd(A_LO, d); chk("R5 ack wins", d, 8'h79);
    // R6 / R10 latching while disabled
    wr(A_LO, 8'h00);
    tmr_ovf = 1; tick(); tmr_ovf = 0;
    rd(A_LO, d); chk("R10 tmr flag", d, 8'h04);
    tick(2);
    rd(A_LO, d); chk("R6 flag held", d, 8'h04);
    chk("R6 no irq when disabled", {7'h0, irq}, 8'h00);
    nvm_done = 1; tick(); nvm_done = 0;
    rd(A_AUX, d); chk("R10 nvm flag", d, 8'h01);
    wr(A_AUX, 8'hFE);
    rd(A_AUX, d); chk("R6 nvm cleared", d, 8'h00);
    // R7 hardware set beats clearing write
    bus_addr = A_LO; bus_wdata = 8'h00; bus_wr = 1; tmr_ovf = 1;
    tick(); bus_wr = 0; tmr_ovf = 0;
    rd(A_LO, d); chk("R7 hw wins", d, 8'h04);
    wr(A_LO, 8'h00);
    // R8 rising edge and latency
    ext_rise = 1; ext_pin = 1;
    tick(2); rd(A_LO, d); chk("R8 not yet", d & 8'h02, 8'h00);
    tick();  rd(A_LO, d); chk("R8 rising", d & 8'h02, 8'h02);
    wr(A_LO, 8'h00);
    ext_pin = 0; tick(4);
    rd(A_LO, d); chk("R8 falling ignored", d, 8'h00);
    ext_rise = 0; ext_pin = 1; tick(4);
    rd(A_LO, d); chk("R8 rising ignored", d, 8'h00);
    ext_pin = 0; tick(3);
    rd(A_LO, d); chk("R8 falling", d, 8'h02);
    wr(A_LO, 8'h00);
    // R9 port change
    port_hi = 4'b0100;
    tick(2); rd(A_LO, d); chk("R9 not yet", d, 8'h00);
    tick();  rd(A_LO, d); chk("R9 change", d, 8'h01);
    wr(A_LO, 8'h00); tick(4);
    rd(A_LO, d); chk("R9 steady", d, 8'h00);
    // random phase against the model (R2, R3, R6, R7)
    for (int i = 0; i < 4000; i++) begin
      chk("R2/R6 random read", bus_rdata, exp_read(bus_addr, m_ctrl, m_nvm));
      chk("R3 random irq", {7'h0, irq}, {7'h0, exp_irq(m_ctrl, m_nvm)});
      case ($urandom_range(3))
        0: bus_addr = A_LO;
        1: bus_addr = A_HI;
        2: bus_addr = A_AUX;
        default: bus_addr = A_NONE;
      endcase
      bus_wr     = ($urandom_range(3) == 0);
      bus_wdata  = 8'($urandom());
      tmr_ovf    = ($urandom_range(7) == 0);
      nvm_done   = ($urandom_range(7) == 0);
      irq_ack    = ($urandom_range(7) == 0);
      ret_strobe = ($urandom_range(5) == 0);
      if ($urandom_range(3) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(4) == 0) port_hi = 4'($urandom());
      if ($urandom_range(63) == 0) ext_rise = ~ext_rise;
      tick();
    end
    done = 1;
    summary();
  end
endmodule